// File: doc/BRIEF.md
# Pixel Histogram and Line-Projection Accumulator

This block sits on the pixel clock of a video pipeline and gathers per-frame statistics into a 512-word by 24-bit accumulation store. Each cycle it takes one 9-bit grey value with a valid strobe. In histogram mode the grey value picks a bin and that bin counts up by one. In projection mode the block reads a value from a lookup table, indexed by the column count. It adds the row count to that value to form a 10-bit sum, and either the low or the high nine bits of the sum name the bin. The grey value is then added into that bin. Applied with suitable tables, this builds the line projections used by a modified Hough transform.

In parallel, a four-page, 512-entry, 9-bit lookup table transforms the pixel stream point by point and drives a video output. Built-in column and row counters supply the coordinates. A clear sequencer zeroes the store before a frame. The store's contents are undefined until the first clear. A plain write port fills the lookup pages and a one-cycle read port returns single bins.

Top module: `hough_hist_accum`

## Requirements
- R1: While rst_n is low and on release: video_out, x_count, y_count, bin_rdata are zero and clr_busy is low.
- R2: x_count and y_count are 9-bit counters. A clear input forces zero on the next edge and wins over its increment input. An increment alone adds one, modulo 512. With neither input high the count holds.
- R3: With op_mode = 1 (histogram), a valid pixel adds 1 to the bin whose address equals the pixel value. A pixel with pix_valid low changes no bin.
- R4: video_out equals the lookup entry of page lut_page at index pix_data (or at x_count when op_mode = 0), two clock edges after the pixel is presented.
- R5: With op_mode = 0 (projection), s = T[lut_page][x_count] + y_count is formed as 10 bits. The bin is s[8:0] when proj_hi_bits = 0 and s[9:1] when proj_hi_bits = 1. A valid pixel adds its grey value to that bin. The counts used are those present with the pixel.
- R6: Valid pixels on consecutive cycles that hit the same bin all accumulate, with no lost update.
- R7: Bin values wrap modulo 2^24.
- R8: A clr_start pulse while idle raises clr_busy for exactly 512 cycles, after which every bin reads zero. Pixels presented during the clear leave no trace.
- R9: op_mode = 2 and op_mode = 3 change no bin.
- R10: bin_rdata returns the bin at bin_raddr one clock edge after the address is presented.
- R11: A tbl_we pulse stores tbl_wdata at entry tbl_waddr of page tbl_wpage. The other pages are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_data | input | 9 | Grey value of the current pixel |
| pix_valid | input | 1 | Pixel strobe |
| op_mode | input | 2 | 0 projection, 1 histogram, 2 reserved, 3 locate (idle) |
| lut_page | input | 2 | Active lookup page |
| proj_hi_bits | input | 1 | Projection bin from high (1) or low (0) sum bits |
| x_inc | input | 1 | Column counter increment |
| x_clr | input | 1 | Column counter clear |
| y_inc | input | 1 | Row counter increment |
| y_clr | input | 1 | Row counter clear |
| clr_start | input | 1 | Start clearing the store |
| tbl_we | input | 1 | Lookup write strobe |
| tbl_wpage | input | 2 | Lookup write page |
| tbl_waddr | input | 9 | Lookup write index |
| tbl_wdata | input | 9 | Lookup write data |
| bin_raddr | input | 9 | Bin read address |
| bin_rdata | output | 24 | Bin read data |
| video_out | output | 9 | Transformed pixel |
| x_count | output | 9 | Column count |
| y_count | output | 9 | Row count |
| clr_busy | output | 1 | Clear in progress |

## Verification
The checker watches the counters on every cycle: clear priority, the step by one and holding. It also checks that a clear start raises the busy flag, and it measures each busy window against the 512-cycle length. The bins themselves, the video delay, the forwarding on repeated addresses, the wrap at 2^24 and the suppression of pixels during a clear or in idle modes only show through the bench's scenarios. The bench reads every bin back and compares it with a model of the store.

// File: rtl/hha_pkg.sv
// Shared types for the accumulation datapath.
// Assumes: the operating mode arrives as a 2-bit code on a plain port.
package hha_pkg;
    typedef enum logic [1:0] {
        MODE_PROJ   = 2'd0,
        MODE_HIST   = 2'd1,
        MODE_RSVD   = 2'd2,
        MODE_LOCATE = 2'd3
    } op_mode_e;
endpackage

// File: rtl/hha_coord_counter.sv
// Coordinate counter: clear wins over increment, wraps at 2**W.
// Assumes: synchronous active-low reset.
module hha_coord_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    // Count register with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/hha_lut_mem.sv
// Paged lookup memory with one write port and one registered read port.
// Assumes: contents are loaded before use; read data resets to zero.
module hha_lut_mem #(
    parameter int PAGES = 4,
    parameter int DEPTH = 512,
    parameter int DW    = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(PAGES*DEPTH)-1:0] waddr,
    input  logic [DW-1:0]                 wdata,
    input  logic [$clog2(PAGES*DEPTH)-1:0] raddr,
    output logic [DW-1:0]                 rdata
);
    localparam int WORDS = PAGES * DEPTH;

    logic [DW-1:0] mem [WORDS];

    // Table write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered table read
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/hha_accum_mem.sv
// Accumulation store: one write port, two registered read ports
// (one for the update pipeline, one for readout).
// Assumes: contents are undefined until cleared by the caller.
module hha_accum_mem #(
    parameter int DEPTH = 512,
    parameter int DW    = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] ra_addr,
    output logic [DW-1:0]            ra_data,
    input  logic [$clog2(DEPTH)-1:0] rb_addr,
    output logic [DW-1:0]            rb_data
);
    logic [DW-1:0] mem [DEPTH];

    // Bin write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered reads for the pipeline and for readout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_data <= '0;
            rb_data <= '0;
        end else begin
            ra_data <= mem[ra_addr];
            rb_data <= mem[rb_addr];
        end
    end
endmodule

// File: rtl/hha_clear_seq.sv
// Clear sequencer: walks every address once, one per cycle, after a start.
// Assumes: a start while busy is ignored.
module hha_clear_seq #(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic                     busy,
    output logic [$clog2(DEPTH)-1:0] addr
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Sweep state and address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            addr <= '0;
        end else if (busy) begin
            if (addr == LAST) busy <= 1'b0;
            addr <= addr + 1'b1;
        end else if (start) begin
            busy <= 1'b1;
            addr <= '0;
        end
    end
endmodule

// File: rtl/hough_hist_accum.sv
// Histogram / line-projection accumulator with a concurrent lookup transform.
// Pipeline: S0 pixel in, lookup read -> S1 bin address -> S2 bin read,
// add, write. A one-entry write-back register forwards the previous write
// so back-to-back hits on one bin accumulate correctly.
// Assumes: the store is cleared before first use; synchronous active-low reset.
module hough_hist_accum #(
    parameter int PIX_W = 9,
    parameter int ACC_W = 24,
    parameter int PAGES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PIX_W-1:0]         pix_data,
    input  logic                     pix_valid,
    input  logic [1:0]               op_mode,
    input  logic [$clog2(PAGES)-1:0] lut_page,
    input  logic                     proj_hi_bits,
    input  logic                     x_inc,
    input  logic                     x_clr,
    input  logic                     y_inc,
    input  logic                     y_clr,
    input  logic                     clr_start,
    input  logic                     tbl_we,
    input  logic [$clog2(PAGES)-1:0] tbl_wpage,
    input  logic [PIX_W-1:0]         tbl_waddr,
    input  logic [PIX_W-1:0]         tbl_wdata,
    input  logic [PIX_W-1:0]         bin_raddr,
    output logic [ACC_W-1:0]         bin_rdata,
    output logic [PIX_W-1:0]         video_out,
    output logic [PIX_W-1:0]         x_count,
    output logic [PIX_W-1:0]         y_count,
    output logic                     clr_busy
);
    import hha_pkg::*;

    localparam int DEPTH = 1 << PIX_W;
    localparam int PG_W  = $clog2(PAGES);
    localparam int SUM_W = PIX_W + 1;

    // ---------------- S0: mode decode, counters, lookup read ----------------
    op_mode_e          mode;
    logic              acc_req;
    logic [PIX_W-1:0]  lut_idx;
    logic [PIX_W-1:0]  lut_q;
    logic [PG_W+PIX_W-1:0] clr_dummy_unused;

    // Decode the mode and the lookup index for this pixel
    always_comb begin
        mode    = op_mode_e'(op_mode);
        lut_idx = (mode == MODE_PROJ) ? x_count : pix_data;
        acc_req = pix_valid && !clr_busy &&
                  ((mode == MODE_PROJ) || (mode == MODE_HIST));
        clr_dummy_unused = '0;
    end

    hha_coord_counter #(.W(PIX_W)) u_xcnt (
        .clk(clk), .rst_n(rst_n), .inc(x_inc), .clr(x_clr), .count(x_count)
    );

    hha_coord_counter #(.W(PIX_W)) u_ycnt (
        .clk(clk), .rst_n(rst_n), .inc(y_inc), .clr(y_clr), .count(y_count)
    );

    hha_lut_mem #(.PAGES(PAGES), .DEPTH(DEPTH), .DW(PIX_W)) u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr ({tbl_wpage, tbl_waddr}),
        .wdata (tbl_wdata),
        .raddr ({lut_page, lut_idx}),
        .rdata (lut_q)
    );

    // ---------------- S1: bin address and addend ----------------
    logic              s1_v;
    logic              s1_proj;
    logic              s1_hi;
    logic [PIX_W-1:0]  s1_pix;
    logic [PIX_W-1:0]  s1_y;
    logic [SUM_W-1:0]  proj_sum;
    logic [PIX_W-1:0]  s1_addr;
    logic [ACC_W-1:0]  s1_add;

    // Capture the pixel context alongside the lookup read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_proj <= 1'b0;
            s1_hi   <= 1'b0;
            s1_pix  <= '0;
            s1_y    <= '0;
        end else begin
            s1_v    <= acc_req;
            s1_proj <= (mode == MODE_PROJ);
            s1_hi   <= proj_hi_bits;
            s1_pix  <= pix_data;
            s1_y    <= y_count;
        end
    end

    // Transformed pixel leaves one register after the lookup
    always_ff @(posedge clk) begin
        if (!rst_n) video_out <= '0;
        else        video_out <= lut_q;
    end

    // Form the bin address from the pixel or from lookup plus row
    always_comb begin
        proj_sum = SUM_W'(lut_q) + SUM_W'(s1_y);
        if (s1_proj) begin
            s1_addr = s1_hi ? proj_sum[SUM_W-1:1] : proj_sum[PIX_W-1:0];
            s1_add  = ACC_W'(s1_pix);
        end else begin
            s1_addr = s1_pix;
            s1_add  = ACC_W'(1);
        end
    end

    // ---------------- S2: read, forward, add, write ----------------
    logic              s2_v;
    logic [PIX_W-1:0]  s2_addr;
    logic [ACC_W-1:0]  s2_add;
    logic [ACC_W-1:0]  s2_old;
    logic [ACC_W-1:0]  s2_base;
    logic [ACC_W-1:0]  s2_new;
    logic              lw_v;
    logic [PIX_W-1:0]  lw_addr;
    logic [ACC_W-1:0]  lw_data;
    logic              mem_we;
    logic [PIX_W-1:0]  mem_waddr;
    logic [ACC_W-1:0]  mem_wdata;
    logic [PIX_W-1:0]  clr_addr;

    // Carry the update to the write stage; a clear kills it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_addr <= '0;
            s2_add  <= '0;
        end else begin
            s2_v    <= s1_v && !clr_busy;
            s2_addr <= s1_addr;
            s2_add  <= s1_add;
        end
    end

    // Merge the last write into the stale read, then add
    always_comb begin
        s2_base = (lw_v && (lw_addr == s2_addr)) ? lw_data : s2_old;
        s2_new  = s2_base + s2_add;
    end

    // Choose between clearing and accumulating for the write port
    always_comb begin
        mem_we    = clr_busy || s2_v;
        mem_waddr = clr_busy ? clr_addr : s2_addr;
        mem_wdata = clr_busy ? '0 : s2_new;
    end

    // Remember the write just issued for forwarding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_v    <= 1'b0;
            lw_addr <= '0;
            lw_data <= '0;
        end else begin
            lw_v    <= mem_we;
            lw_addr <= mem_waddr;
            lw_data <= mem_wdata;
        end
    end

    hha_clear_seq #(.DEPTH(DEPTH)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_start),
        .busy  (clr_busy),
        .addr  (clr_addr)
    );

    hha_accum_mem #(.DEPTH(DEPTH), .DW(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .ra_addr (s1_addr),
        .ra_data (s2_old),
        .rb_addr (bin_raddr),
        .rb_data (bin_rdata)
    );
endmodule

// File: rtl/hha_checks.sv
// Cycle checks on the counters and the clear sequencer, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module hha_checks #(
    parameter int PIX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             x_inc,
    input logic             x_clr,
    input logic [PIX_W-1:0] x_count,
    input logic             y_inc,
    input logic             y_clr,
    input logic [PIX_W-1:0] y_count,
    input logic             clr_start,
    input logic             clr_busy
);
    localparam int DEPTH = 1 << PIX_W;
    localparam int LEN_W = PIX_W + 2;

    logic [LEN_W-1:0] busy_len;

    // Length of the current clear window
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_len <= '0;
        else if (clr_busy) busy_len <= busy_len + 1'b1;
        else               busy_len <= '0;
    end

    assert_xclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        x_clr |=> (x_count == '0));
    assert_xinc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_inc && !x_clr) |=> (x_count == $past(x_count) + 1'b1));
    assert_yclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        y_clr |=> (y_count == '0));
    assert_yhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!y_inc && !y_clr) |=> $stable(y_count));
    assert_clr_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start && !clr_busy) |=> clr_busy);
    assert_clr_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_busy) |-> (busy_len == LEN_W'(DEPTH)));
endmodule

bind hough_hist_accum hha_checks #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_inc     (x_inc),
    .x_clr     (x_clr),
    .x_count   (x_count),
    .y_inc     (y_inc),
    .y_clr     (y_clr),
    .y_count   (y_count),
    .clr_start (clr_start),
    .clr_busy  (clr_busy)
);

// File: tb/sim_hough_hist_accum.sv
module sim_hough_hist_accum;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 9;
    localparam int ACC_W = 24;
    localparam int PAGES = 4;
    localparam int DEPTH = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] pix_data = '0;
    logic pix_valid = 1'b0;
    logic [1:0] op_mode = 2'd1;
    logic [1:0] lut_page = '0;
    logic proj_hi_bits = 1'b0;
    logic x_inc = 1'b0, x_clr = 1'b0, y_inc = 1'b0, y_clr = 1'b0;
    logic clr_start = 1'b0;
    logic tbl_we = 1'b0;
    logic [1:0] tbl_wpage = '0;
    logic [8:0] tbl_waddr = '0, tbl_wdata = '0;
    logic [8:0] bin_raddr = '0;
    logic [23:0] bin_rdata;
    logic [8:0] video_out, x_count, y_count;
    logic clr_busy;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [8:0]  lut_m [PAGES*DEPTH];
    logic [23:0] acc_m [DEPTH];
    logic [8:0]  mx = '0, my = '0;
    bit          vid_en = 1'b0;
    int          vid_n = 0;
    logic [8:0]  vid_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hough_hist_accum #(.PIX_W(PIX_W), .ACC_W(ACC_W), .PAGES(PAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
        .op_mode(op_mode), .lut_page(lut_page), .proj_hi_bits(proj_hi_bits),
        .x_inc(x_inc), .x_clr(x_clr), .y_inc(y_inc), .y_clr(y_clr),
        .clr_start(clr_start), .tbl_we(tbl_we), .tbl_wpage(tbl_wpage),
        .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .bin_raddr(bin_raddr),
        .bin_rdata(bin_rdata), .video_out(video_out), .x_count(x_count),
        .y_count(y_count), .clr_busy(clr_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] proj_bin(input logic [8:0] t, input logic [8:0] y, input bit hi);
        logic [9:0] s;
        s = {1'b0, t} + {1'b0, y};
        return hi ? s[9:1] : s[8:0];
    endfunction

    // One pixel cycle: drive, update the model, advance one clock
    task automatic pixel(input logic [8:0] p, input bit v, input logic [1:0] m,
                         input logic [1:0] pg, input bit hi,
                         input bit xi, input bit xc, input bit yi, input bit yc);
        logic [8:0] idx, t, b, vexp;
        pix_data = p; pix_valid = v; op_mode = m; lut_page = pg; proj_hi_bits = hi;
        x_inc = xi; x_clr = xc; y_inc = yi; y_clr = yc;
        idx  = (m == 2'd0) ? mx : p;
        vexp = lut_m[{pg, idx}];
        if (v && m == 2'd1) acc_m[p] = acc_m[p] + 24'd1;
        if (v && m == 2'd0) begin
            t = lut_m[{pg, mx}];
            b = proj_bin(t, my, hi);
            acc_m[b] = acc_m[b] + {15'd0, p};
        end
        if (xc) mx = '0; else if (xi) mx = mx + 9'd1;
        if (yc) my = '0; else if (yi) my = my + 9'd1;
        @(negedge clk);
        if (vid_en) begin
            if (vid_n >= 1) check(video_out == vid_prev, "R4 video", video_out, vid_prev);
            vid_n++;
        end
        vid_prev = vexp;
    endtask

    task automatic idle(input int n);
        pix_valid = 1'b0; x_inc = 0; x_clr = 0; y_inc = 0; y_clr = 0;
        repeat (n) @(negedge clk);
    endtask

    // Read every bin through the read port (R10) and compare with the model
    task automatic check_bins(input string req);
        int bad = 0;
        int ba = 0;
        logic [23:0] act = '0;
        idle(4);
        for (int a = 0; a < DEPTH; a++) begin
            bin_raddr = a[8:0];
            @(negedge clk);
            if (bin_rdata !== acc_m[a] && bad == 0) begin
                ba = a; act = bin_rdata;
            end
            if (bin_rdata !== acc_m[a]) bad++;
        end
        check(bad == 0, req, act, acc_m[ba]);
        if (bad != 0) $display("  first mismatch at bin %0d (R10 read port)", ba);
    endtask

    // Clear the store; optionally send pixels during the clear (R8)
    task automatic clear_store(input bit noisy);
        int n = 0;
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        check(clr_busy == 1'b1, "R8 busy rises", clr_busy, 1);
        while (clr_busy && n < 2000) begin
            pix_data = $urandom % DEPTH;
            pix_valid = noisy;
            op_mode = 2'd1;
            @(negedge clk);
            n++;
        end
        pix_valid = 1'b0;
        check(n == DEPTH, "R8 busy length", n, DEPTH);
        for (int a = 0; a < DEPTH; a++) acc_m[a] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2f41));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(video_out == 0 && x_count == 0 && y_count == 0 && !clr_busy && bin_rdata == 0,
              "R1 reset outputs", {video_out, x_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(video_out == 0 && !clr_busy, "R1 after release", video_out, 0);

        // R2: counters
        x_clr = 1; y_clr = 1; @(negedge clk);
        x_clr = 0; y_clr = 0; x_inc = 1; repeat (3) @(negedge clk);
        x_inc = 0; @(negedge clk);
        check(x_count == 9'd3, "R2 x increment/hold", x_count, 3);
        x_inc = 1; x_clr = 1; @(negedge clk);
        check(x_count == 9'd0, "R2 x clear priority", x_count, 0);
        x_inc = 0; x_clr = 0; y_inc = 1; repeat (DEPTH + 2) @(negedge clk);
        y_inc = 0; @(negedge clk);
        check(y_count == 9'd2, "R2 y wrap", y_count, 2);
        y_clr = 1; @(negedge clk); y_clr = 0;
        check(y_count == 9'd0, "R2 y clear", y_count, 0);
        mx = '0; my = '0;

        // R11: load all lookup pages
        for (int a = 0; a < PAGES*DEPTH; a++) begin
            tbl_we = 1; tbl_wpage = a[10:9]; tbl_waddr = a[8:0];
            tbl_wdata = $urandom % DEPTH;
            lut_m[a] = tbl_wdata;
            @(negedge clk);
        end
        tbl_we = 0;

        // R8: clear with pixels arriving during it
        clear_store(1'b1);
        check_bins("R8 store zero after clear");

        // R4/R11: video transform across pages, with histogram running (R3)
        vid_en = 1; vid_n = 0;
        for (int i = 0; i < 600; i++)
            pixel($urandom % DEPTH, ($urandom % 4) != 0, 2'd1, $urandom % PAGES, 0, 0, 0, 0, 0);
        // R4 corner: extreme pixel values
        pixel(9'd0, 1, 2'd1, 2'd3, 0, 0, 0, 0, 0);
        pixel(9'd511, 1, 2'd1, 2'd0, 0, 0, 0, 0, 0);
        pixel(9'd511, 0, 2'd1, 2'd2, 0, 0, 0, 0, 0);
        vid_en = 0;
        check_bins("R3 R11 histogram random");

        // R6: back-to-back hits on one bin, then invalid pixels (R3)
        for (int i = 0; i < 7; i++) pixel(9'd77, 1, 2'd1, 0, 0, 0, 0, 0, 0);
        pixel(9'd78, 1, 2'd1, 0, 0, 0, 0, 0, 0);
        pixel(9'd77, 1, 2'd1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) pixel(9'd77, 0, 2'd1, 0, 0, 0, 0, 0, 0);
        check_bins("R6 R3 repeated bin");

        // R9: idle modes change nothing
        for (int i = 0; i < 200; i++)
            pixel($urandom % DEPTH, 1, (i % 2 == 0) ? 2'd2 : 2'd3, $urandom % PAGES, 0, 0, 0, 0, 0);
        check_bins("R9 idle modes");

        // R5: projection, low then high sum bits
        for (int h = 0; h < 2; h++) begin
            clear_store(1'b0);
            x_clr = 1; y_clr = 1; @(negedge clk); mx = 0; my = 0;
            for (int i = 0; i < 3000; i++) begin
                bit eol;
                eol = ($urandom % 37) == 0;
                pixel($urandom % DEPTH, ($urandom % 8) != 0, 2'd0, h[1:0] + 2'd1, h[0],
                      !eol, eol, eol, ($urandom % 500) == 0);
            end
            check_bins(h == 0 ? "R5 projection low bits" : "R5 projection high bits");
        end

        // R7: wrap modulo 2^24 on one bin with forwarding (R6)
        clear_store(1'b0);
        for (int i = 0; i < 33000; i++) pixel(9'd511, 1, 2'd0, 2'd2, 0, 0, 1, 0, 1);
        check_bins("R7 wrap");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule